// File: doc/BRIEF.md
# DTMF tone-pair frequency classifier

This block takes two limited square-wave inputs, one carrying the low tone group and one carrying the high tone group. It measures each input's frequency by counting system-clock cycles between rising edges. Each input first passes through a synchroniser. The block then adds four consecutive periods into one window sum and compares that sum against a tolerance band around the nominal window of each standard dual-tone frequency. Every band is computed at elaboration time from the clock-frequency parameter, whose default is 3.579545 MHz.

A group becomes valid only when two consecutive windows fall into the same band. A window that falls outside every band, or a silence on the input, removes validity straight away. The early-steering output is high only while both groups are valid at the same time. This averaging lets the block tolerate small frequency deviations and reject short speech-like bursts. A duration-validation stage downstream uses the early-steering output together with the two 2-bit indices to register a key.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: A low-group input of 697, 770, 852 or 941 Hz yields low index 0, 1, 2 or 3 respectively on `low_idx_o`.
- R2: A high-group input of 1209, 1336, 1477 or 1633 Hz yields high index 0, 1, 2 or 3 respectively on `high_idx_o`.
- R3: A band spans the nominal four-period cycle count (NPER*CLK_HZ/f) plus or minus 1/TOL_DIV of it (2.5 % by default). The bands never overlap. A tone 1.5 % off a nominal frequency is still classified to that nominal frequency. A tone roughly 4 % off, such as 725 Hz on the low input or 1161 Hz on the high input, matches no band.
- R4: `est_o` is high only while both groups are valid. If one group is missing or matches no band, `est_o` stays low.
- R5: A group becomes valid only after two consecutive in-band windows that hit the same band. A pair burst too short to complete two low-group windows never raises `est_o`.
- R6: A window that matches no band clears that group's validity on the next cycle, which drops `est_o`.
- R7: If no rising edge arrives within the group's longest in-band window, that group's validity is cleared and `est_o` drops.
- R8: `low_idx_o` and `high_idx_o` do not change while `est_o` stays high.
- R9: During and directly after reset, `est_o` is 0 and both indices are 0.
- R10: Each of the 16 low/high pairings raises `est_o` with both indices correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ Hz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_tone_i | input | 1 | Limited low-group tone, asynchronous |
| high_tone_i | input | 1 | Limited high-group tone, asynchronous |
| est_o | output | 1 | Both groups currently hold a valid tone |
| low_idx_o | output | 2 | Low-group tone index |
| high_idx_o | output | 2 | High-group tone index |

## Verification
Each input edge reaches the period counter three cycles after the input rises. A group's validity changes one cycle after the edge that closes a window. This means `est_o` and the indices settle within the third complete low-group window after a frequency change, which is about 3.5k cycles at the bench clock rate. The bench therefore waits 4600 cycles before it samples on a falling clock edge. A loss of a tone shows within one window, and a silence shows within one group timeout. The negative checks wait well beyond both. The cycle-exact relations are covered by properties: a missed window or timeout clears `est_o` on the next cycle, a rise in validity follows an in-band window, and the indices hold steady while `est_o` is high.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;
  localparam int NBIN  = 4;
  localparam int IDX_W = 2;
  localparam int GRP_LO = 0;
  localparam int GRP_HI = 1;

  function automatic int tone_hz(input int grp, input int idx);
    int lo_t [NBIN];
    int hi_t [NBIN];
    lo_t = '{697, 770, 852, 941};
    hi_t = '{1209, 1336, 1477, 1633};
    return (grp == GRP_LO) ? lo_t[idx] : hi_t[idx];
  endfunction

  function automatic int win_nom(input int clk_hz, input int nper, input int hz);
    return (nper * clk_hz) / hz;
  endfunction

  // longest in-band window of a group: upper edge of its lowest tone
  function automatic int win_max(input int clk_hz, input int nper, input int tol_div,
                                 input int grp);
    int n;
    n = win_nom(clk_hz, nper, tone_hz(grp, 0));
    return n + n / tol_div;
  endfunction
endpackage

// File: rtl/tone_edge_sync.sv
module tone_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tone_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], tone_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tone_period_meter.sv
module tone_period_meter #(
  parameter int NPER  = 4,
  parameter int TMO   = 1000,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] sum_o,
  output logic             tmo_o
);
  localparam int PC_W  = $clog2(NPER + 1);
  localparam int GAP_W = $clog2(TMO + 1);

  logic             armed_q;
  logic [PC_W-1:0]  per_q;
  logic [CNT_W-1:0] win_q, win_inc;
  logic [GAP_W-1:0] gap_q;

  assign win_inc = (&win_q) ? win_q : win_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      per_q      <= '0;
      win_q      <= '0;
      gap_q      <= '0;
      meas_vld_o <= 1'b0;
      sum_o      <= '0;
      tmo_o      <= 1'b0;
    end else begin
      meas_vld_o <= 1'b0;
      tmo_o      <= 1'b0;
      if (rise_i) begin
        gap_q <= '0;
        if (!armed_q) begin
          armed_q <= 1'b1;
          per_q   <= '0;
          win_q   <= '0;
        end else if (per_q == PC_W'(NPER - 1)) begin
          meas_vld_o <= 1'b1;
          sum_o      <= win_inc;
          per_q      <= '0;
          win_q      <= '0;
        end else begin
          per_q <= per_q + 1'b1;
          win_q <= win_inc;
        end
      end else if (armed_q) begin
        if (gap_q == GAP_W'(TMO)) begin
          tmo_o   <= 1'b1;
          armed_q <= 1'b0;
          gap_q   <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
          win_q <= win_inc;
        end
      end
    end
  end
endmodule

// File: rtl/tone_bin_classifier.sv
module tone_bin_classifier
  import dtmf_cls_pkg::*;
#(
  parameter int GRP     = GRP_LO,
  parameter int CLK_HZ  = 3579545,
  parameter int NPER    = 4,
  parameter int TOL_DIV = 40,
  parameter int CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] sum_i,
  input  logic             tmo_i,
  output logic [NBIN-1:0]  hit_o,
  output logic             any_hit_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] bin;
  logic             last_hit_q;
  logic [IDX_W-1:0] last_bin_q;

  for (genvar b = 0; b < NBIN; b++) begin : g_bin
    localparam int NOM = win_nom(CLK_HZ, NPER, tone_hz(GRP, b));
    localparam logic [CNT_W-1:0] LO_B = CNT_W'(NOM - NOM / TOL_DIV);
    localparam logic [CNT_W-1:0] HI_B = CNT_W'(NOM + NOM / TOL_DIV);
    assign hit_o[b] = (sum_i >= LO_B) && (sum_i <= HI_B);
  end

  assign any_hit_o = |hit_o;

  always_comb begin
    bin = '0;
    for (int b = NBIN - 1; b >= 0; b--) begin
      if (hit_o[b]) bin = IDX_W'(b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_hit_q <= 1'b0;
      last_bin_q <= '0;
      valid_o    <= 1'b0;
      idx_o      <= '0;
    end else if (tmo_i) begin
      last_hit_q <= 1'b0;
      valid_o    <= 1'b0;
    end else if (meas_vld_i) begin
      if (any_hit_o) begin
        last_hit_q <= 1'b1;
        last_bin_q <= bin;
        if (last_hit_q && (bin == last_bin_q)) begin
          valid_o <= 1'b1;
          idx_o   <= bin;
        end else begin
          valid_o <= 1'b0;
        end
      end else begin
        last_hit_q <= 1'b0;
        valid_o    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
  import dtmf_cls_pkg::*;
#(
  parameter int CLK_HZ  = 3579545,
  parameter int NPER    = 4,
  parameter int TOL_DIV = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       low_tone_i,
  input  logic       high_tone_i,
  output logic       est_o,
  output logic [1:0] low_idx_o,
  output logic [1:0] high_idx_o
);
  localparam int TMO_MAX = win_max(CLK_HZ, NPER, TOL_DIV, GRP_LO);
  localparam int CNT_W   = $clog2(NPER * TMO_MAX + 1);

  logic [1:0]       tone_in;
  logic [1:0]       rise;
  logic [1:0]       meas_vld;
  logic [1:0]       tmo;
  logic [1:0]       any_hit;
  logic [1:0]       grp_valid;
  logic [CNT_W-1:0] sum [2];
  logic [NBIN-1:0]  hit [2];
  logic [IDX_W-1:0] idx [2];
  logic [2*NBIN-1:0] hit_flat;

  assign tone_in = {high_tone_i, low_tone_i};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int TMO = win_max(CLK_HZ, NPER, TOL_DIV, g);

    tone_edge_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tone_i (tone_in[g]),
      .rise_o (rise[g])
    );

    tone_period_meter #(.NPER(NPER), .TMO(TMO), .CNT_W(CNT_W)) u_meter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise[g]),
      .meas_vld_o (meas_vld[g]),
      .sum_o      (sum[g]),
      .tmo_o      (tmo[g])
    );

    tone_bin_classifier #(
      .GRP(g), .CLK_HZ(CLK_HZ), .NPER(NPER), .TOL_DIV(TOL_DIV), .CNT_W(CNT_W)
    ) u_cls (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .meas_vld_i (meas_vld[g]),
      .sum_i      (sum[g]),
      .tmo_i      (tmo[g]),
      .hit_o      (hit[g]),
      .any_hit_o  (any_hit[g]),
      .valid_o    (grp_valid[g]),
      .idx_o      (idx[g])
    );

    assign hit_flat[g*NBIN +: NBIN] = hit[g];
  end

  assign est_o      = grp_valid[GRP_LO] & grp_valid[GRP_HI];
  assign low_idx_o  = idx[GRP_LO];
  assign high_idx_o = idx[GRP_HI];
endmodule

// File: rtl/dtmf_pair_classifier_chk.sv
module dtmf_pair_classifier_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       est_o,
  input logic [1:0] low_idx_o,
  input logic [1:0] high_idx_o,
  input logic [1:0] meas_vld,
  input logic [1:0] any_hit,
  input logic [1:0] tmo,
  input logic [1:0] grp_valid,
  input logic [7:0] hit_flat
);
  p_idx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (est_o && $past(est_o)) |-> ($stable(low_idx_o) && $stable(high_idx_o)));

  p_est_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grp_valid[0] || !grp_valid[1]) |-> !est_o);

  p_bins_disjoint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_flat[3:0]) && $onehot0(hit_flat[7:4]));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_miss_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_vld[g] && !any_hit[g]) |=> (!grp_valid[g] && !est_o));

    p_tmo_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo[g] |=> (!grp_valid[g] && !est_o));

    p_rise_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(grp_valid[g]) |-> $past(meas_vld[g] && any_hit[g]));
  end
endmodule

bind dtmf_pair_classifier dtmf_pair_classifier_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .est_o      (est_o),
  .low_idx_o  (low_idx_o),
  .high_idx_o (high_idx_o),
  .meas_vld   (meas_vld),
  .any_hit    (any_hit),
  .tmo        (tmo),
  .grp_valid  (grp_valid),
  .hit_flat   (hit_flat)
);

// File: tb/tb_dtmf_pair_classifier.sv
module tb_dtmf_pair_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ_TB  = 200000;
  localparam int SETTLE     = 4600;
  localparam int WDOG       = 190000;
  localparam int LO_HZ [4] = '{697, 770, 852, 941};
  localparam int HI_HZ [4] = '{1209, 1336, 1477, 1633};
  // stimulus/expected vector: [3:2] low index, [1:0] high index
  localparam logic [3:0] VEC [16] = '{4'h5, 4'h0, 4'hA, 4'hF, 4'h3, 4'hC, 4'h6, 4'h9,
                                      4'h1, 4'hE, 4'h7, 4'h8, 4'h2, 4'hD, 4'h4, 4'hB};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       low_tone_i, high_tone_i;
  logic       est_o;
  logic [1:0] low_idx_o, high_idx_o;

  int  lo_f = 0, hi_f = 0;
  int  lo_acc = 0, hi_acc = 0;
  logic lo_lvl = 1'b0, hi_lvl = 1'b0;
  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  mon_en = 1'b0, est_seen = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dtmf_pair_classifier #(.CLK_HZ(CLK_HZ_TB)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .low_tone_i (low_tone_i),
    .high_tone_i(high_tone_i),
    .est_o      (est_o),
    .low_idx_o  (low_idx_o),
    .high_idx_o (high_idx_o)
  );

  assign low_tone_i  = lo_lvl;
  assign high_tone_i = hi_lvl;

  // phase-accumulator tone generators, mean period CLK_HZ_TB/f cycles
  always @(negedge clk_i) begin
    if (lo_f == 0) begin lo_lvl = 1'b0; lo_acc = 0; end
    else begin
      lo_acc = lo_acc + 2 * lo_f;
      if (lo_acc >= CLK_HZ_TB) begin lo_acc = lo_acc - CLK_HZ_TB; lo_lvl = ~lo_lvl; end
    end
    if (hi_f == 0) begin hi_lvl = 1'b0; hi_acc = 0; end
    else begin
      hi_acc = hi_acc + 2 * hi_f;
      if (hi_acc >= CLK_HZ_TB) begin hi_acc = hi_acc - CLK_HZ_TB; hi_lvl = ~hi_lvl; end
    end
    if (mon_en && est_o) est_seen = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    wait_cyc(3);
    chk("R9 est in reset", int'(est_o), 0);
    chk("R9 low idx in reset", int'(low_idx_o), 0);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk("R9 est after reset", int'(est_o), 0);
    chk("R9 high idx after reset", int'(high_idx_o), 0);

    // R10 / R1 / R2: all pairings from the vector table
    for (int i = 0; i < 16; i++) begin
      lo_f = LO_HZ[VEC[i][3:2]];
      hi_f = HI_HZ[VEC[i][1:0]];
      wait_cyc(SETTLE);
      chk("R10 est for pair", int'(est_o), 1);
      chk("R1 low idx", int'(low_idx_o), int'(VEC[i][3:2]));
      chk("R2 high idx", int'(high_idx_o), int'(VEC[i][1:0]));
    end

    // R3: 1.5 % deviation still accepted
    lo_f = 707; hi_f = 1609;
    wait_cyc(SETTLE);
    chk("R3 est off-nominal", int'(est_o), 1);
    chk("R3 low idx off-nominal", int'(low_idx_o), 0);
    chk("R3 high idx off-nominal", int'(high_idx_o), 3);

    // R6: low goes out of band -> est drops
    lo_f = 600;
    wait_cyc(SETTLE);
    chk("R6 est after low out of band", int'(est_o), 0);

    // R3: about 4 % off is rejected
    lo_f = 725; hi_f = 1336;
    wait_cyc(SETTLE);
    chk("R3 est 725 Hz low", int'(est_o), 0);
    lo_f = 770; hi_f = 1161;
    wait_cyc(SETTLE);
    chk("R3 est 1161 Hz high", int'(est_o), 0);

    // R4: only one group present
    hi_f = 0;
    wait_cyc(SETTLE);
    chk("R4 est with high silent", int'(est_o), 0);

    // R7: valid pair, then high goes silent
    hi_f = 1477;
    wait_cyc(SETTLE);
    chk("R7 est before silence", int'(est_o), 1);
    hi_f = 0;
    wait_cyc(1500);
    chk("R7 est after high silence", int'(est_o), 0);

    // R5: short burst never raises est
    lo_f = 0; hi_f = 0;
    wait_cyc(2500);
    est_seen = 1'b0;
    mon_en   = 1'b1;
    lo_f = 697; hi_f = 1209;
    wait_cyc(1750);
    lo_f = 0; hi_f = 0;
    wait_cyc(2000);
    mon_en = 1'b0;
    chk("R5 short burst est seen", int'(est_seen), 0);

    // R8: indices steady over a long valid interval
    lo_f = 852; hi_f = 1633;
    wait_cyc(SETTLE);
    chk("R8 est held pair", int'(est_o), 1);
    wait_cyc(3000);
    chk("R8 low idx held", int'(low_idx_o), 2);
    chk("R8 high idx held", int'(high_idx_o), 3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule